// File: doc/BRIEF.md
# Peak-and-Hold Solenoid Current Controller

This block switches the gate of a low-side coil switch so that the coil current follows a two-level profile. A strong pull-in level comes first and lasts for a fixed number of cycles. A weaker holding level follows and lasts for as long as the actuation request stays high. When the request falls, the gate opens and the coil current decays. The block closes the loop on a stream of current codes from a sense converter. It keeps each level inside a programmable band by switching the gate on and off. It does not use a fixed duty cycle.

Each actuation leaves a record, captured at the moment the decay finishes. The record holds the highest code seen during pull-in, the cycles spent before the pull-in level was first reached, the length of pull-in, the last holding code and the length of the decay.

The shape of the current waveform also sorts the load into one of four cases:
- A current that never leaves the floor within a short sample window means an open harness.
- A current that climbs to the overcurrent ceiling means a short.
- A pull-in that ends without reaching its level means a high-resistance path.

Open and short faults latch and cut the drive. No new actuation starts until the fault is cleared. Protection never re-arms the drive by itself.

Top module: `pnh_coil_top`

## Requirements
- R1: After reset the gate is off, the phase is idle (code 0), all three fault flags are clear and every evidence output is zero.
- R2: In idle with no latched fault, a rising edge of `actReq` moves the phase to pull-in (code 1) and turns the gate on in the same edge. A request that is merely held high starts nothing.
- R3: Pull-in lasts exactly `peakCycles` cycles and is then followed by hold (code 2), unless a fault or a falling request ends it first. Hold is only ever entered from pull-in.
- R4: During pull-in and hold, a sample at or above the active target (`peakTarget` in pull-in, `holdTarget` in hold) turns the gate off for the next cycle. A sample below target minus `bandCode` turns it back on. Samples in between leave the gate as it is. With a coil that steps 10 codes per cycle and a band of 10, the highest pull-in sample equals a `peakTarget` that is a multiple of 10. Once settled, hold samples stay within [holdTarget−band−10, holdTarget+9].
- R5: A falling `actReq` in pull-in or hold moves the phase to release (code 3) with the gate off in the next cycle. Release ends with a return to idle in the first cycle whose sample lies below `openMinCode`. The gate is never on in idle or release.
- R6: On the return from release to idle, the evidence outputs capture five values:
  - `evPeakMax`: the highest pull-in sample.
  - `evRiseCycles`: the pull-in cycles before the one whose sample first reaches `peakTarget`. This equals the whole pull-in length if the level is never reached.
  - `evPeakCycles`: the pull-in length.
  - `evHoldLevel`: the last hold sample.
  - `evReleaseCycles`: the release length.
- R7: A sample at or above `ocLimit` in pull-in or hold sets `faultShort`, turns the gate off in the next cycle and enters release. This check takes priority over every other exit.
- R8: If `riseWindow` pull-in samples have been taken and neither they nor the current sample reached `openMinCode`, then `faultOpen` is set, the gate turns off in the next cycle and release is entered.
- R9: A pull-in that runs its full length without any sample reaching `peakTarget` sets `faultHighRes` and still continues into hold. The flag clears at the next start.
- R10: While `faultOpen` or `faultShort` is set, no actuation starts. The two flags clear only when `faultClear` is asserted in idle, and a fresh rising edge of `actReq` is then needed to start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| actReq | input | 1 | Actuation request; its rising edge starts, its fall releases |
| faultClear | input | 1 | Clears the latched open and short flags while idle |
| peakTarget | input | CODE_W | Pull-in current target, in ADC codes |
| holdTarget | input | CODE_W | Hold current target, in ADC codes |
| bandCode | input | CODE_W | Width of the hysteresis band below each target |
| peakCycles | input | CNT_W | Pull-in length in cycles (at least 1) |
| ocLimit | input | CODE_W | Overcurrent ceiling, in ADC codes |
| openMinCode | input | CODE_W | Floor code: open-load threshold and end-of-decay threshold |
| riseWindow | input | CNT_W | Samples allowed in pull-in before the floor must be crossed |
| sampleValid | input | 1 | Marks `sampleCode` as a new current sample |
| sampleCode | input | CODE_W | Coil current sample |
| gateOn | output | 1 | Low-side switch gate drive |
| phase | output | 2 | 0 idle, 1 pull-in, 2 hold, 3 release |
| faultOpen | output | 1 | Latched open-load fault |
| faultShort | output | 1 | Latched overcurrent fault |
| faultHighRes | output | 1 | High-resistance indication for the last actuation |
| evPeakMax | output | CODE_W | Evidence: highest pull-in sample |
| evRiseCycles | output | CNT_W | Evidence: cycles before the pull-in target was reached |
| evPeakCycles | output | CNT_W | Evidence: pull-in length |
| evHoldLevel | output | CODE_W | Evidence: last hold sample |
| evReleaseCycles | output | CNT_W | Evidence: release length |

## Verification
The assertions assume four things:
- Configuration inputs stay constant from a start until the return to idle.
- `sampleCode` reflects the coil current that results from the previous cycle's gate level.
- `peakCycles` is at least one.
- In normal runs `ocLimit` sits above `peakTarget`.

The stimulus meets these assumptions in two ways. A bench coil model raises or lowers the current by a fixed step on every cycle, according to the gate. Configuration changes only while the phase reads idle. The sweeps cover:
- several pull-in targets and pull-in lengths;
- a coil with no current rise;
- a coil whose first crossing of the floor sits exactly on either side of the sample window;
- a saturating coil;
- a coil that reaches the overcurrent ceiling.

// File: rtl/pnh_coil_pkg.sv
package pnh_coil_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PEAK = 2'd1,
    PH_HOLD = 2'd2,
    PH_REL  = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic startPeak;
    logic inPeak;
    logic inHold;
    logic inRel;
    logic killGate;
    logic latchEv;
  } ctlStrobe_t;

  // raw waveform observations from datapath to control
  typedef struct packed {
    logic ocHit;
    logic openFail;
    logic peakTimeUp;
    logic peakReached;
    logic releaseDone;
  } dpStatus_t;

endpackage

// File: rtl/pnh_coil_dp.sv
module pnh_coil_dp
  import pnh_coil_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic [CODE_W-1:0] peakTarget,
  input  logic [CODE_W-1:0] holdTarget,
  input  logic [CODE_W-1:0] bandCode,
  input  logic [CNT_W-1:0]  peakCycles,
  input  logic [CODE_W-1:0] ocLimit,
  input  logic [CODE_W-1:0] openMinCode,
  input  logic [CNT_W-1:0]  riseWindow,
  output dpStatus_t         status,
  output logic              gateOn,
  output logic [CODE_W-1:0] evPeakMax,
  output logic [CNT_W-1:0]  evRiseCycles,
  output logic [CNT_W-1:0]  evPeakCycles,
  output logic [CODE_W-1:0] evHoldLevel,
  output logic [CNT_W-1:0]  evReleaseCycles
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   EXT_ONE = (CNT_W+1)'(1);

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_SAT) ? v : v + CNT_ONE;
  endfunction

  // working registers for the actuation in progress
  logic [CNT_W-1:0]  peakLen;
  logic [CNT_W-1:0]  riseCnt;
  logic [CNT_W-1:0]  smpCnt;
  logic [CNT_W-1:0]  relCnt;
  logic [CODE_W-1:0] peakMax;
  logic [CODE_W-1:0] holdLast;
  logic              peakSeen;
  logic              openSeen;

  logic [CODE_W-1:0] activeTgt;
  logic [CODE_W:0]   bandSum;
  logic              atTop;
  logic              belowBand;
  logic              peakNow;
  logic              crossNow;

  always_comb begin
    activeTgt = ctl.inHold ? holdTarget : peakTarget;
    bandSum   = {1'b0, sampleCode} + {1'b0, bandCode};
    atTop     = sampleValid && (sampleCode >= activeTgt);
    belowBand = sampleValid && (bandSum < {1'b0, activeTgt});
    peakNow   = sampleValid && (sampleCode >= peakTarget);
    crossNow  = sampleValid && (sampleCode >= openMinCode);

    status.ocHit       = sampleValid && (sampleCode >= ocLimit);
    status.openFail    = (smpCnt >= riseWindow) && !openSeen && !crossNow;
    status.peakTimeUp  = (({1'b0, peakLen} + EXT_ONE) >= {1'b0, peakCycles});
    status.peakReached = peakSeen || peakNow;
    status.releaseDone = (sampleValid && (sampleCode < openMinCode)) || (relCnt == CNT_SAT);
  end

  // hysteretic gate
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateOn <= 1'b0;
    end else if (ctl.startPeak) begin
      gateOn <= 1'b1;
    end else if (ctl.killGate) begin
      gateOn <= 1'b0;
    end else if (ctl.inPeak || ctl.inHold) begin
      if (atTop)          gateOn <= 1'b0;
      else if (belowBand) gateOn <= 1'b1;
    end else begin
      gateOn <= 1'b0;
    end
  end

  // waveform measurement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakLen  <= '0;
      riseCnt  <= '0;
      smpCnt   <= '0;
      relCnt   <= '0;
      peakMax  <= '0;
      holdLast <= '0;
      peakSeen <= 1'b0;
      openSeen <= 1'b0;
    end else if (ctl.startPeak) begin
      peakLen  <= '0;
      riseCnt  <= '0;
      smpCnt   <= '0;
      relCnt   <= '0;
      peakMax  <= '0;
      holdLast <= '0;
      peakSeen <= 1'b0;
      openSeen <= 1'b0;
    end else begin
      if (ctl.inPeak) begin
        peakLen <= satInc(peakLen);
        if (!peakSeen && !peakNow) riseCnt <= satInc(riseCnt);
        if (peakNow)  peakSeen <= 1'b1;
        if (crossNow) openSeen <= 1'b1;
        if (sampleValid) smpCnt <= satInc(smpCnt);
        if (sampleValid && (sampleCode > peakMax)) peakMax <= sampleCode;
      end
      if (ctl.inHold && sampleValid) holdLast <= sampleCode;
      if (ctl.inRel) relCnt <= satInc(relCnt);
    end
  end

  // evidence record, frozen at the end of release
  always_ff @(posedge clk) begin
    if (!rstN) begin
      evPeakMax       <= '0;
      evRiseCycles    <= '0;
      evPeakCycles    <= '0;
      evHoldLevel     <= '0;
      evReleaseCycles <= '0;
    end else if (ctl.latchEv) begin
      evPeakMax       <= peakMax;
      evRiseCycles    <= riseCnt;
      evPeakCycles    <= peakLen;
      evHoldLevel     <= holdLast;
      evReleaseCycles <= satInc(relCnt);
    end
  end

  // R6
  ev_rise_le_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.latchEv) |-> (evRiseCycles <= evPeakCycles));

endmodule

// File: rtl/pnh_coil_ctl.sv
module pnh_coil_ctl
  import pnh_coil_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       actReq,
  input  logic       faultClear,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output phase_e     phase,
  output logic       faultOpen,
  output logic       faultShort,
  output logic       faultHighRes
);

  phase_e state;
  phase_e nextState;
  logic   prevAct;
  logic   actRise;
  logic   latched;
  logic   setShort;
  logic   setOpen;
  logic   setHigh;

  assign actRise = actReq && !prevAct;
  assign latched = faultOpen || faultShort;
  assign phase   = state;

  always_comb begin
    nextState = state;
    ctl       = '0;
    setShort  = 1'b0;
    setOpen   = 1'b0;
    setHigh   = 1'b0;
    unique case (state)
      PH_IDLE: begin
        if (actRise && !latched) begin
          ctl.startPeak = 1'b1;
          nextState     = PH_PEAK;
        end
      end
      PH_PEAK: begin
        ctl.inPeak = 1'b1;
        if (status.ocHit) begin
          ctl.killGate = 1'b1;
          setShort     = 1'b1;
          nextState    = PH_REL;
        end else if (status.openFail) begin
          ctl.killGate = 1'b1;
          setOpen      = 1'b1;
          nextState    = PH_REL;
        end else if (!actReq) begin
          ctl.killGate = 1'b1;
          nextState    = PH_REL;
        end else if (status.peakTimeUp) begin
          setHigh   = !status.peakReached;
          nextState = PH_HOLD;
        end
      end
      PH_HOLD: begin
        ctl.inHold = 1'b1;
        if (status.ocHit) begin
          ctl.killGate = 1'b1;
          setShort     = 1'b1;
          nextState    = PH_REL;
        end else if (!actReq) begin
          ctl.killGate = 1'b1;
          nextState    = PH_REL;
        end
      end
      PH_REL: begin
        ctl.inRel = 1'b1;
        if (status.releaseDone) begin
          ctl.latchEv = 1'b1;
          nextState   = PH_IDLE;
        end
      end
      default: nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= PH_IDLE;
      prevAct      <= 1'b0;
      faultOpen    <= 1'b0;
      faultShort   <= 1'b0;
      faultHighRes <= 1'b0;
    end else begin
      state   <= nextState;
      prevAct <= actReq;
      if (setShort)                            faultShort <= 1'b1;
      else if (state == PH_IDLE && faultClear) faultShort <= 1'b0;
      if (setOpen)                             faultOpen <= 1'b1;
      else if (state == PH_IDLE && faultClear) faultOpen <= 1'b0;
      if (ctl.startPeak)                       faultHighRes <= 1'b0;
      else if (setHigh)                        faultHighRes <= 1'b1;
    end
  end

  // R3
  hold_from_peak_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_HOLD) |-> ($past(state) == PH_PEAK || $past(state) == PH_HOLD));

  // R10
  latched_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE && latched && !faultClear) |=> (state == PH_IDLE));

endmodule

// File: rtl/pnh_coil_top.sv
module pnh_coil_top
  import pnh_coil_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actReq,
  input  logic              faultClear,
  input  logic [CODE_W-1:0] peakTarget,
  input  logic [CODE_W-1:0] holdTarget,
  input  logic [CODE_W-1:0] bandCode,
  input  logic [CNT_W-1:0]  peakCycles,
  input  logic [CODE_W-1:0] ocLimit,
  input  logic [CODE_W-1:0] openMinCode,
  input  logic [CNT_W-1:0]  riseWindow,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] sampleCode,
  output logic              gateOn,
  output logic [1:0]        phase,
  output logic              faultOpen,
  output logic              faultShort,
  output logic              faultHighRes,
  output logic [CODE_W-1:0] evPeakMax,
  output logic [CNT_W-1:0]  evRiseCycles,
  output logic [CNT_W-1:0]  evPeakCycles,
  output logic [CODE_W-1:0] evHoldLevel,
  output logic [CNT_W-1:0]  evReleaseCycles
);

  ctlStrobe_t ctl;
  dpStatus_t  status;
  phase_e     phaseInt;

  assign phase = phaseInt;

  pnh_coil_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .actReq       (actReq),
    .faultClear   (faultClear),
    .status       (status),
    .ctl          (ctl),
    .phase        (phaseInt),
    .faultOpen    (faultOpen),
    .faultShort   (faultShort),
    .faultHighRes (faultHighRes)
  );

  pnh_coil_dp #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .ctl             (ctl),
    .sampleValid     (sampleValid),
    .sampleCode      (sampleCode),
    .peakTarget      (peakTarget),
    .holdTarget      (holdTarget),
    .bandCode        (bandCode),
    .peakCycles      (peakCycles),
    .ocLimit         (ocLimit),
    .openMinCode     (openMinCode),
    .riseWindow      (riseWindow),
    .status          (status),
    .gateOn          (gateOn),
    .evPeakMax       (evPeakMax),
    .evRiseCycles    (evRiseCycles),
    .evPeakCycles    (evPeakCycles),
    .evHoldLevel     (evHoldLevel),
    .evReleaseCycles (evReleaseCycles)
  );

  // R5
  gate_off_idle_rel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseInt == PH_IDLE || phaseInt == PH_REL) |-> !gateOn);

  // R7
  oc_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phaseInt == PH_PEAK || phaseInt == PH_HOLD) && sampleValid && sampleCode >= ocLimit)
      |=> (!gateOn && faultShort && phaseInt == PH_REL));

  // R8
  open_gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultOpen) |-> (!gateOn && phaseInt == PH_REL));

  // R2
  start_gate_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseInt == PH_PEAK && $past(phaseInt) == PH_IDLE) |-> gateOn);

endmodule

// File: tb/pnh_coil_top_tb.sv
module pnh_coil_top_tb;

  localparam int CODE_W = 12;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic actReq = 1'b0;
  logic faultClear = 1'b0;
  logic [CODE_W-1:0] peakTarget = 12'd100;
  logic [CODE_W-1:0] holdTarget = 12'd50;
  logic [CODE_W-1:0] bandCode = 12'd10;
  logic [CNT_W-1:0]  peakCycles = 16'd20;
  logic [CODE_W-1:0] ocLimit = 12'd200;
  logic [CODE_W-1:0] openMinCode = 12'd5;
  logic [CNT_W-1:0]  riseWindow = 16'd4;
  logic sampleValid = 1'b1;
  logic [CODE_W-1:0] sampleCode;
  logic gateOn;
  logic [1:0] phase;
  logic faultOpen, faultShort, faultHighRes;
  logic [CODE_W-1:0] evPeakMax, evHoldLevel;
  logic [CNT_W-1:0] evRiseCycles, evPeakCycles, evReleaseCycles;

  always #2 clk = ~clk;

  pnh_coil_top #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .actReq(actReq), .faultClear(faultClear),
    .peakTarget(peakTarget), .holdTarget(holdTarget), .bandCode(bandCode),
    .peakCycles(peakCycles), .ocLimit(ocLimit), .openMinCode(openMinCode),
    .riseWindow(riseWindow), .sampleValid(sampleValid), .sampleCode(sampleCode),
    .gateOn(gateOn), .phase(phase), .faultOpen(faultOpen), .faultShort(faultShort),
    .faultHighRes(faultHighRes), .evPeakMax(evPeakMax), .evRiseCycles(evRiseCycles),
    .evPeakCycles(evPeakCycles), .evHoldLevel(evHoldLevel), .evReleaseCycles(evReleaseCycles)
  );

  // coil model: steps by coilUp while the gate is on, falls by coilDn otherwise
  int coilUp = 10;
  int coilDn = 10;
  int coilCap = 250;
  int cur = 0;
  assign sampleCode = CODE_W'(cur);

  always @(negedge clk) begin
    if (!rstN) cur <= 0;
    else if (gateOn) cur <= (cur + coilUp > coilCap) ? coilCap : cur + coilUp;
    else cur <= (cur > coilDn) ? cur - coilDn : 0;
  end

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // per-run observations
  int nPeak, nHold, nRel, nGate, relGate, holdLastObs, holdMin, holdMax;
  bit settled;

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe();
    if (gateOn) nGate++;
    case (phase)
      2'd1: nPeak++;
      2'd2: begin
        nHold++;
        holdLastObs = int'(sampleCode);
        if (int'(sampleCode) <= int'(holdTarget)) settled = 1;
        if (settled) begin
          if (int'(sampleCode) < holdMin) holdMin = int'(sampleCode);
          if (int'(sampleCode) > holdMax) holdMax = int'(sampleCode);
        end
      end
      2'd3: begin
        nRel++;
        if (gateOn) relGate++;
      end
      default: ;
    endcase
  endtask

  task automatic runAct(input int onCycles);
    nPeak = 0; nHold = 0; nRel = 0; nGate = 0; relGate = 0;
    holdLastObs = 0; holdMin = 1 << 20; holdMax = -1; settled = 0;
    @(negedge clk); #1;
    actReq = 1'b1;
    for (int i = 0; i < onCycles; i++) begin
      @(negedge clk); #1;
      observe();
    end
    actReq = 1'b0;
    for (int g = 0; g < 2000 && phase != 2'd0; g++) begin
      @(negedge clk); #1;
      observe();
    end
  endtask

  task automatic pulseClear();
    @(negedge clk); #1; faultClear = 1'b1;
    @(negedge clk); #1; faultClear = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // watchdog
  int cycleCount = 0;
  always @(posedge clk) begin
    cycleCount++;
    if (cycleCount > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycleCount, 150000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    checkEq("R1 gate", int'(gateOn), 0);
    checkEq("R1 phase", int'(phase), 0);
    checkEq("R1 faults", int'({faultOpen, faultShort, faultHighRes}), 0);
    checkEq("R1 evidence", int'(evPeakMax) + int'(evRiseCycles) + int'(evPeakCycles)
            + int'(evHoldLevel) + int'(evReleaseCycles), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    checkEq("R1 idle after reset", int'(phase), 0);

    // R2/R3/R4/R5/R6 sweep over pull-in targets and lengths
    for (int pt = 40; pt <= 120; pt += 20) begin
      for (int pc = 14; pc <= 20; pc += 6) begin
        peakTarget = CODE_W'(pt);
        peakCycles = CNT_W'(pc);
        runAct(pc + 12);
        checkEq("R3 pull-in cycles", nPeak, pc);
        checkEq("R3 hold cycles", nHold, 12);
        checkEq("R4 peak max", int'(evPeakMax), pt);
        checkEq("R6 rise cycles", int'(evRiseCycles), pt / 10 - 1);
        checkEq("R6 peak cycles", int'(evPeakCycles), pc);
        checkEq("R6 hold level", int'(evHoldLevel), holdLastObs);
        checkEq("R6 release cycles", int'(evReleaseCycles), nRel);
        checkEq("R5 gate in release", relGate, 0);
        checkEq("R5 back to idle", int'(phase), 0);
        checkEq("R4 hold settled", int'(settled), 1);
        checkEq("R4 hold min in band", int'(holdMin >= 30), 1);
        checkEq("R4 hold max in band", int'(holdMax <= 59), 1);
        checkEq("R9 no high-res", int'(faultHighRes), 0);
        checkEq("R2 gate off at end", int'(gateOn), 0);
      end
    end

    // R5/R6 early release during pull-in
    peakTarget = 12'd100; peakCycles = 16'd20;
    runAct(6);
    checkEq("R5 abort pull-in cycles", nPeak, 6);
    checkEq("R6 abort peak cycles", int'(evPeakCycles), 6);
    checkEq("R6 abort rise cycles", int'(evRiseCycles), 6);
    checkEq("R6 abort peak max", int'(evPeakMax), 60);
    checkEq("R9 abort not high-res", int'(faultHighRes), 0);

    // R7 short: ceiling reached at the sixth pull-in sample
    ocLimit = 12'd60;
    runAct(30);
    checkEq("R7 short flag", int'(faultShort), 1);
    checkEq("R7 pull-in cycles", nPeak, 6);
    checkEq("R7 gate-on cycles", nGate, 6);
    checkEq("R7 no hold", nHold, 0);
    checkEq("R6 short peak max", int'(evPeakMax), 60);
    // R10 latched: a new edge starts nothing
    ocLimit = 12'd200;
    runAct(10);
    checkEq("R10 blocked pull-in", nPeak, 0);
    checkEq("R10 blocked gate", nGate, 0);
    checkEq("R10 short still set", int'(faultShort), 1);
    pulseClear();
    checkEq("R10 short cleared", int'(faultShort), 0);
    runAct(32);
    checkEq("R10 restart pull-in", nPeak, 20);
    checkEq("R10 restart peak max", int'(evPeakMax), 100);

    // R8 open: no current at all
    coilUp = 0;
    runAct(30);
    checkEq("R8 open flag", int'(faultOpen), 1);
    checkEq("R8 pull-in cycles", nPeak, 5);
    checkEq("R8 gate-on cycles", nGate, 5);
    checkEq("R8 release cycles", int'(evReleaseCycles), 1);
    checkEq("R8 not high-res", int'(faultHighRes), 0);
    pulseClear();
    checkEq("R10 open cleared", int'(faultOpen), 0);

    // R8 boundary: crossing at the fifth sample just misses the floor
    coilUp = 1; openMinCode = 12'd6;
    runAct(30);
    checkEq("R8 boundary open", int'(faultOpen), 1);
    checkEq("R8 boundary pull-in", nPeak, 5);
    checkEq("R8 boundary peak max", int'(evPeakMax), 5);
    pulseClear();

    // R8/R9 boundary: crossing at the fifth sample meets the floor
    openMinCode = 12'd5;
    runAct(30);
    checkEq("R8 boundary no open", int'(faultOpen), 0);
    checkEq("R9 high-res flag", int'(faultHighRes), 1);
    checkEq("R9 continues to hold", nHold, 10);
    checkEq("R9 pull-in cycles", nPeak, 20);
    checkEq("R9 peak max", int'(evPeakMax), 20);
    checkEq("R9 rise equals length", int'(evRiseCycles), 20);

    // R9 saturating coil, then cleared by the next start
    coilUp = 10; coilCap = 70;
    runAct(30);
    checkEq("R9 saturated high-res", int'(faultHighRes), 1);
    checkEq("R9 saturated peak max", int'(evPeakMax), 70);
    coilCap = 250;
    runAct(30);
    checkEq("R9 cleared on start", int'(faultHighRes), 0);
    checkEq("R6 rise after clear", int'(evRiseCycles), 9);

    finishRun();
  end

endmodule